// File: doc/BRIEF.md
# Processor status word flag unit

This block holds the 8-bit program status word of a small 8-bit microcontroller core and derives its arithmetic flags. Each cycle the core presents an ALU operation class together with the two operands, an incoming carry and the current accumulator value. Add, add-with-carry and subtract-with-borrow operations set the carry, half carry and overflow flags from internal sums. Multiply and divide clear the carry and half carry flags and set overflow according to their own rules. Any other operation class leaves the arithmetic flags alone.

Software reaches the register through a special-function-register write port. It can write the whole byte at address 0xD0 or change a single bit at bit address 0xD0 + n. The parity bit is never stored. It is recomputed at all times from the accumulator, and writes to it are dropped. The two bank-select bits drive the base address of the active working-register bank in the core's register file.

Top module: `psw_flag_unit`

## Requirements
- R1: Reset (active-low `rst_n`) clears every stored bit, so `psw_rdata` reads 0x00 while the accumulator is 0x00, and `bank_base` reads 0x00.
- R2: `psw_rdata` is laid out from bit 7 down as CY, AC, F0, RS1, RS0, OV, F1, PAR. PAR (bit 0) follows the accumulator without a clock edge and is 1 when `acc` has an odd number of one bits. Writes aimed at bit 0 have no effect.
- R3: `alu_op` is 1 for ADD and 2 for ADDC. For these, CY is the carry out of bit 7 and AC is the carry out of bit 3. `carry_in` is added only for ADDC.
- R4: `alu_op` 3 is SUBB, which computes a - b - `carry_in`. CY is set on a borrow out of bit 7 and AC on a borrow out of the low nibble.
- R5: For ADD, ADDC and SUBB, OV is set exactly when the 8-bit signed result overflows, and is cleared otherwise.
- R6: `alu_op` 4 is MUL. It sets OV when the 16-bit product exceeds 255, clears OV otherwise, and clears CY and AC.
- R7: `alu_op` 5 is DIV. It sets OV when the divisor `op_b` is zero, clears OV otherwise, and clears CY and AC.
- R8: `alu_op` 0 (any other operation) leaves CY, AC and OV unchanged.
- R9: A byte write (`sfr_wr_byte`) at `sfr_addr` 0xD0 loads bits 7..1 from `sfr_wdata` on the clock edge. A byte write at any other address changes nothing.
- R10: A bit write (`sfr_wr_bit`) at `bit_addr` 0xD0 + n, with n from 1 to 7, loads bit n from `bit_val`. Bit addresses outside 0xD0..0xD7 change nothing.
- R11: When an ALU update and a software write fall in the same cycle, the written bits take the software value and the untargeted arithmetic flags take the ALU result.
- R12: `bank_base` equals RS1:RS0 times 8 (0x00, 0x08, 0x10 or 0x18). It follows the stored bits, so it changes after the clock edge that takes in a write.
- R13: F0, F1 and the bank-select bits change only through software writes. ALU operations never alter them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alu_op | input | 3 | Operation class: 0 other, 1 ADD, 2 ADDC, 3 SUBB, 4 MUL, 5 DIV |
| op_a | input | 8 | First operand (minuend, multiplicand, dividend) |
| op_b | input | 8 | Second operand (subtrahend, multiplier, divisor) |
| carry_in | input | 1 | Incoming carry or borrow for ADDC and SUBB |
| acc | input | 8 | Current accumulator value, used for parity |
| sfr_wr_byte | input | 1 | Byte write strobe |
| sfr_addr | input | 8 | Byte write address |
| sfr_wdata | input | 8 | Byte write data |
| sfr_wr_bit | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address; bits 2..0 pick the bit |
| bit_val | input | 1 | Value for the single-bit write |
| psw_rdata | output | 8 | Full register image including live parity |
| bank_base | output | 5 | Base address of the selected register bank |

## Verification
An ALU flag update and a software write to the register can land in the same cycle. The bench provokes this by presenting an ADD together with a single-bit write to F1 or CY, and again together with a full byte write. The readback after that edge must show the written bits carrying the software value. Any arithmetic flag the write did not target must carry the value the ADD alone would have produced.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int DATA_W      = 8;
    localparam int NIB_W       = DATA_W / 2;
    localparam int SEL_W       = 2;
    localparam int BANK_SPAN   = 8;
    localparam int SPAN_W      = $clog2(BANK_SPAN);
    localparam int BASE_W      = SEL_W + SPAN_W;
    localparam int ADDR_W      = 8;
    localparam int IDX_W       = $clog2(DATA_W);
    localparam logic [ADDR_W-1:0] PSW_ADDR = 8'hD0;

    localparam int POS_PAR = 0;

    typedef enum logic [2:0] {
        ALU_OTHER = 3'd0,
        ALU_ADD   = 3'd1,
        ALU_ADDC  = 3'd2,
        ALU_SUBB  = 3'd3,
        ALU_MUL   = 3'd4,
        ALU_DIV   = 3'd5
    } alu_op_e;

    typedef struct packed {
        logic             cy;
        logic             ac;
        logic             f0;
        logic [SEL_W-1:0] rs;
        logic             ov;
        logic             f1;
    } psw_state_t;

    typedef struct packed {
        logic upd;
        logic cy;
        logic ac;
        logic ov;
    } alu_flags_t;
endpackage

// File: rtl/psw_arith_flags.sv
module psw_arith_flags
    import psw_pkg::*;
(
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output alu_flags_t        flags
);
    logic              c_eff;
    logic [DATA_W:0]   sum_w;
    logic [NIB_W:0]    nib_sum;
    logic [DATA_W:0]   diff_w;
    logic [NIB_W:0]    nib_diff;
    logic [2*DATA_W-1:0] prod;
    logic              add_ovf;
    logic              sub_ovf;

    always_comb begin
        c_eff    = (op == ALU_ADDC || op == ALU_SUBB) ? cin : 1'b0;
        sum_w    = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, c_eff};
        nib_sum  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
        diff_w   = {1'b0, a} - {1'b0, b} - {{DATA_W{1'b0}}, c_eff};
        nib_diff = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]} - {{NIB_W{1'b0}}, c_eff};
        prod     = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
        add_ovf  = (a[DATA_W-1] == b[DATA_W-1]) && (sum_w[DATA_W-1] != a[DATA_W-1]);
        sub_ovf  = (a[DATA_W-1] != b[DATA_W-1]) && (diff_w[DATA_W-1] != a[DATA_W-1]);

        flags = '0;
        unique case (op)
            ALU_ADD, ALU_ADDC: begin
                flags.upd = 1'b1;
                flags.cy  = sum_w[DATA_W];
                flags.ac  = nib_sum[NIB_W];
                flags.ov  = add_ovf;
            end
            ALU_SUBB: begin
                flags.upd = 1'b1;
                flags.cy  = diff_w[DATA_W];
                flags.ac  = nib_diff[NIB_W];
                flags.ov  = sub_ovf;
            end
            ALU_MUL: begin
                flags.upd = 1'b1;
                flags.ov  = |prod[2*DATA_W-1:DATA_W];
            end
            ALU_DIV: begin
                flags.upd = 1'b1;
                flags.ov  = (b == '0);
            end
            default: flags = '0;
        endcase
    end
endmodule

// File: rtl/psw_sfr_decode.sv
module psw_sfr_decode
    import psw_pkg::*;
(
    input  logic              wr_byte,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_bit,
    input  logic [ADDR_W-1:0] baddr,
    input  logic              bval,
    output logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] wval
);
    logic             byte_hit;
    logic             bit_blk_hit;
    logic [IDX_W-1:0] bit_idx;

    assign byte_hit    = wr_byte && (addr == PSW_ADDR);
    assign bit_blk_hit = wr_bit && (baddr[ADDR_W-1:IDX_W] == PSW_ADDR[ADDR_W-1:IDX_W]);
    assign bit_idx     = baddr[IDX_W-1:0];

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        logic bit_hit;
        assign bit_hit = bit_blk_hit && (bit_idx == IDX_W'(i));
        if (i == POS_PAR) begin : g_ro
            assign wmask[i] = 1'b0;
            assign wval[i]  = 1'b0;
        end else begin : g_rw
            assign wmask[i] = byte_hit || bit_hit;
            assign wval[i]  = bit_hit ? bval : wdata[i];
        end
    end
endmodule

// File: rtl/psw_bank_map.sv
module psw_bank_map
    import psw_pkg::*;
(
    input  logic [SEL_W-1:0]  rs,
    output logic [BASE_W-1:0] base
);
    assign base = {rs, {SPAN_W{1'b0}}};
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
    import psw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        alu_op,
    input  logic [7:0]        op_a,
    input  logic [7:0]        op_b,
    input  logic              carry_in,
    input  logic [7:0]        acc,
    input  logic              sfr_wr_byte,
    input  logic [7:0]        sfr_addr,
    input  logic [7:0]        sfr_wdata,
    input  logic              sfr_wr_bit,
    input  logic [7:0]        bit_addr,
    input  logic              bit_val,
    output logic [7:0]        psw_rdata,
    output logic [4:0]        bank_base
);
    alu_flags_t        alu_f;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] wval;
    psw_state_t        st_d;
    psw_state_t        st_q;
    psw_state_t        st_alu;
    logic              parity;

    psw_arith_flags u_arith (
        .op    (alu_op),
        .a     (op_a),
        .b     (op_b),
        .cin   (carry_in),
        .flags (alu_f)
    );

    psw_sfr_decode u_dec (
        .wr_byte (sfr_wr_byte),
        .addr    (sfr_addr),
        .wdata   (sfr_wdata),
        .wr_bit  (sfr_wr_bit),
        .baddr   (bit_addr),
        .bval    (bit_val),
        .wmask   (wmask),
        .wval    (wval)
    );

    psw_bank_map u_bank (
        .rs   (st_q.rs),
        .base (bank_base)
    );

    always_comb begin
        st_alu = st_q;
        if (alu_f.upd) begin
            st_alu.cy = alu_f.cy;
            st_alu.ac = alu_f.ac;
            st_alu.ov = alu_f.ov;
        end
        st_d = psw_state_t'((st_alu & ~wmask[DATA_W-1:1]) | (wval[DATA_W-1:1] & wmask[DATA_W-1:1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign parity    = ^acc;
    assign psw_rdata = {st_q, parity};
endmodule

// File: rtl/psw_flag_unit_chk.sv
module psw_flag_unit_chk
    import psw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] alu_op,
    input logic [7:0] op_b,
    input logic [7:0] acc,
    input logic       sfr_wr_byte,
    input logic [7:0] sfr_addr,
    input logic [7:0] sfr_wdata,
    input logic       sfr_wr_bit,
    input logic [7:0] bit_addr,
    input logic [7:0] psw_rdata,
    input logic [4:0] bank_base
);
    logic byte_hit;
    logic any_wr;
    assign byte_hit = sfr_wr_byte && (sfr_addr == PSW_ADDR);
    assign any_wr   = byte_hit || (sfr_wr_bit && (bit_addr[7:3] == PSW_ADDR[7:3]));

    AST_PARITY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        psw_rdata[0] == ^acc); // R2
    AST_BANK_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_base == {psw_rdata[4:3], 3'b000}); // R12
    AST_OTHER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == ALU_OTHER && !any_wr) |=> $stable({psw_rdata[7:6], psw_rdata[2]})); // R8
    AST_MUL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == ALU_MUL && !any_wr) |=> (!psw_rdata[7] && !psw_rdata[6])); // R6
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_op == ALU_DIV && op_b == 8'h00 && !any_wr) |=> (psw_rdata[2] && !psw_rdata[7] && !psw_rdata[6])); // R7
    AST_USER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> $stable({psw_rdata[5:3], psw_rdata[1]})); // R13
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_hit |=> (psw_rdata[7:1] == $past(sfr_wdata[7:1]))); // R11
endmodule

bind psw_flag_unit psw_flag_unit_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alu_op      (alu_op),
    .op_b        (op_b),
    .acc         (acc),
    .sfr_wr_byte (sfr_wr_byte),
    .sfr_addr    (sfr_addr),
    .sfr_wdata   (sfr_wdata),
    .sfr_wr_bit  (sfr_wr_bit),
    .bit_addr    (bit_addr),
    .psw_rdata   (psw_rdata),
    .bank_base   (bank_base)
);

// File: tb/psw_flag_unit_test.sv
module psw_flag_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 18;
    // {op[2:0], a[7:0], b[7:0], cin, exp cy, ac, ov}
    localparam logic [22:0] VEC [N_VEC] = '{
        {3'd1, 8'h01, 8'h01, 1'b0, 3'b000},
        {3'd1, 8'hFF, 8'h01, 1'b0, 3'b110},
        {3'd1, 8'h7F, 8'h01, 1'b0, 3'b011},
        {3'd2, 8'h0E, 8'h01, 1'b1, 3'b010},
        {3'd2, 8'h80, 8'h80, 1'b0, 3'b101},
        {3'd1, 8'h0F, 8'h00, 1'b1, 3'b000},
        {3'd3, 8'h05, 8'h03, 1'b0, 3'b000},
        {3'd3, 8'h80, 8'h01, 1'b0, 3'b011},
        {3'd3, 8'h10, 8'h00, 1'b1, 3'b010},
        {3'd3, 8'h00, 8'h01, 1'b0, 3'b110},
        {3'd4, 8'h10, 8'h10, 1'b0, 3'b001},
        {3'd4, 8'h0F, 8'h11, 1'b0, 3'b000},
        {3'd1, 8'hFF, 8'h01, 1'b0, 3'b110},
        {3'd5, 8'h20, 8'h00, 1'b0, 3'b001},
        {3'd0, 8'hFF, 8'hFF, 1'b1, 3'b001},
        {3'd5, 8'h20, 8'h04, 1'b0, 3'b000},
        {3'd1, 8'hFF, 8'h01, 1'b0, 3'b110},
        {3'd0, 8'h00, 8'h00, 1'b0, 3'b110}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] alu_op = '0;
    logic [7:0] op_a = '0, op_b = '0, acc = '0;
    logic       carry_in = 1'b0;
    logic       sfr_wr_byte = 1'b0, sfr_wr_bit = 1'b0, bit_val = 1'b0;
    logic [7:0] sfr_addr = '0, sfr_wdata = '0, bit_addr = '0;
    logic [7:0] psw_rdata;
    logic [4:0] bank_base;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    psw_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .alu_op(alu_op), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .acc(acc), .sfr_wr_byte(sfr_wr_byte), .sfr_addr(sfr_addr),
        .sfr_wdata(sfr_wdata), .sfr_wr_bit(sfr_wr_bit), .bit_addr(bit_addr),
        .bit_val(bit_val), .psw_rdata(psw_rdata), .bank_base(bank_base)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_op = 3'd0; op_a = '0; op_b = '0; carry_in = 1'b0;
        sfr_wr_byte = 1'b0; sfr_wr_bit = 1'b0; sfr_addr = '0; sfr_wdata = '0;
        bit_addr = '0; bit_val = 1'b0;
    endtask

    task automatic byte_wr(input logic [7:0] ad, input logic [7:0] d);
        sfr_wr_byte = 1'b1; sfr_addr = ad; sfr_wdata = d;
    endtask

    task automatic bit_wr(input logic [7:0] ba, input logic v);
        sfr_wr_bit = 1'b1; bit_addr = ba; bit_val = v;
    endtask

    task automatic alu(input logic [2:0] op, input logic [7:0] a, input logic [7:0] b, input logic c);
        alu_op = op; op_a = a; op_b = b; carry_in = c;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    function automatic string op_req(input logic [2:0] op);
        case (op)
            3'd1, 3'd2: return "R3 R5";
            3'd3:       return "R4 R5";
            3'd4:       return "R6";
            3'd5:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    initial begin
        for (int n = 0; n < 20000; n++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R1 rdata", psw_rdata, 8'h00);
        check("R1 bank", {3'b0, bank_base}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        acc = 8'h01; #1 check("R2 parity odd", psw_rdata, 8'h01);
        acc = 8'h03; #1 check("R2 parity even", psw_rdata, 8'h00);
        acc = 8'hFE; #1 check("R2 parity seven", psw_rdata, 8'h01);
        acc = 8'h00; @(negedge clk);

        for (int i = 0; i < N_VEC; i++) begin
            logic [22:0] v;
            v = VEC[i];
            alu(v[22:20], v[19:12], v[11:4], v[3]);
            tick();
            check(op_req(v[22:20]), psw_rdata, {v[2], v[1], 3'b000, v[0], 2'b00});
        end

        byte_wr(8'hD0, 8'hFF); tick();
        check("R9 R2 byte write", psw_rdata, 8'hFE);
        check("R12 bank 3", {3'b0, bank_base}, 8'h18);
        byte_wr(8'hD1, 8'h00); tick();
        check("R9 wrong address", psw_rdata, 8'hFE);
        byte_wr(8'hD0, 8'h10); tick();
        check("R12 rdata", psw_rdata, 8'h10);
        check("R12 bank 2", {3'b0, bank_base}, 8'h10);
        bit_wr(8'hD5, 1'b1); tick();
        check("R10 bit F0", psw_rdata, 8'h30);
        bit_wr(8'hD0, 1'b1); tick();
        check("R2 bit0 write ignored", psw_rdata, 8'h30);
        bit_wr(8'hE5, 1'b0); tick();
        check("R10 foreign bit address", psw_rdata, 8'h30);
        bit_wr(8'hD1, 1'b1); alu(3'd1, 8'h7F, 8'h01, 1'b0); tick();
        check("R11 bit write plus add", psw_rdata, 8'h76);
        alu(3'd1, 8'hFF, 8'h01, 1'b0); tick();
        check("R13 user bits kept", psw_rdata, 8'hF2);
        byte_wr(8'hD0, 8'h00); alu(3'd1, 8'hFF, 8'h01, 1'b0); tick();
        check("R11 byte write wins", psw_rdata, 8'h00);
        check("R12 bank 0", {3'b0, bank_base}, 8'h00);
        bit_wr(8'hD7, 1'b0); alu(3'd1, 8'hFF, 8'h01, 1'b0); tick();
        check("R11 CY write wins", psw_rdata, 8'h40);
        byte_wr(8'hD0, 8'h08); tick();
        check("R12 bank 1", {3'b0, bank_base}, 8'h08);

        rst_n = 1'b0; #1;
        check("R1 reset mid-run", psw_rdata, 8'h00);
        check("R1 bank after reset", {3'b0, bank_base}, 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule